// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Selectable Write Policy

This block sits between one requester and a slower, word-addressed backing memory. It holds a small direct-mapped store of lines. For each line it keeps a tag, a valid bit and a dirty bit. Requests arrive on a valid/ready port and may be reads or writes. Memory traffic always moves a line-sized beat with a per-word write mask. Each memory transaction is held until the memory acknowledges it, and the memory may take any number of cycles to do so.

A static mode pin picks the write behaviour:
- **Write-through mode:** every write is sent to memory at once. A write miss leaves the cache untouched, and only reads bring lines in.
- **Write-back mode:** writes stay in the cache and mark the line dirty. A write miss first fetches the line and then merges the word. A miss whose victim line is dirty first writes that line out and then fetches the new one.

A flush input walks every line in index order and writes out the dirty ones. Those lines keep their contents and stay valid. The flush ends with a one-cycle done pulse.

Top module: `wpc_cache`

## Requirements
- R1: After reset every line is invalid and clean, `req_ready` is high, `mem_valid` is low and `flush_done` is low, so the first read of any address causes a fill.
- R2: A read that hits raises `rsp_valid` with the word in the cycle right after the acceptance cycle, and it starts no memory transaction.
- R3: A read miss issues one memory read (`mem_write`=0) of the line at `mem_addr` = word address shifted right by the offset width. It then returns the word, and later reads of that line hit.
- R4: In write-through mode (`wb_mode`=0), a write hit updates the cached word and issues one memory write to the line address. The write mask has only bit k set, where k is the word offset, and lane k carries the data. No line ever becomes dirty.
- R5: In write-through mode, a write miss issues the same single-word memory write and leaves the cache contents unchanged, so a later read of that address still misses and fills.
- R6: In write-back mode (`wb_mode`=1), a write hit starts no memory transaction. The new word is returned by later reads of that address.
- R7: In write-back mode, a write miss on a clean or invalid victim issues exactly one line read. It then merges the word into the filled line and starts no memory write.
- R8: In write-back mode, a miss whose victim is valid and dirty issues two memory transactions in order. The first is a full-mask write of the old line to its old line address; the second is the read of the new line.
- R9: A flush writes each dirty line exactly once, with a full mask and in rising index order. Afterwards no line is dirty and every line keeps its validity and data. `flush_done` is high for exactly one cycle at the end.
- R10: `req_ready` is low in the cycle after a request is accepted, and it stays low until that request has finished. It is also low whenever `flush_req` is high.
- R11: While `mem_valid` is high and `mem_ack` is low, `mem_valid`, `mem_write`, `mem_addr`, `mem_wmask` and `mem_wline` hold their values into the next cycle.
- R12: A word address is split as follows: bits [1:0] give the word offset, bits [5:2] give the line index, and the upper bits give the tag. The memory line address is tag and index concatenated. Word k of a line occupies bits [32k+31:32k].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wb_mode | input | 1 | 1 = write-back with write allocation, 0 = write-through without allocation; changed only under reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | WORD_W | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | WORD_W | Read data |
| flush_req | input | 1 | Level request to write out all dirty lines, sampled when idle |
| flush_done | output | 1 | One-cycle pulse at the end of a flush |
| mem_valid | output | 1 | Memory transaction pending |
| mem_ack | input | 1 | Memory completes the pending transaction this cycle |
| mem_write | output | 1 | 1 = write, 0 = line read |
| mem_addr | output | ADDR_W-2 | Line address (tag, index) |
| mem_wmask | output | WORDS | Per-word write enable |
| mem_wline | output | WORDS*WORD_W | Write line |
| mem_rline | input | WORDS*WORD_W | Read line, valid with `mem_ack` |

## Verification
A read hit is due in the negedge sample right after the acceptance edge, with latency count 1. The bench measures this count and requires it for every hit. A miss has no fixed latency, because the memory model waits a random 0 to 3 cycles before each acknowledge. For a miss the bench therefore polls `rsp_valid`, or waits for `req_ready` to return, and then checks the logged order, addresses and masks of the memory transactions. The `flush_done` pulse is sampled at the negedge where it first appears and again one cycle later. Memory contents are compared only after the transaction that writes them has been acknowledged.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOOKUP,
      ST_WRITEBACK,
      ST_FILL,
      ST_WRITE_THRU,
      ST_FLUSH
   } wpc_state_e;
endpackage

// File: rtl/wpc_tag_store.sv
module wpc_tag_store #(
   parameter int LINES = 16,
   parameter int TAG_W = 4,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] idx,
   input  logic             fill_en,
   input  logic [TAG_W-1:0] fill_tag,
   input  logic             dirty_set,
   input  logic             dirty_clr,
   output logic             rd_valid,
   output logic             rd_dirty,
   output logic [TAG_W-1:0] rd_tag,
   output logic [LINES-1:0] valid_vec,
   output logic [LINES-1:0] dirty_vec
);
   logic [TAG_W-1:0] tag_arr [LINES];

   initial begin
      assert (LINES >= 2 && (LINES & (LINES - 1)) == 0)
         else $error("wpc_tag_store: LINES must be a power of two");
   end

   for (genvar i = 0; i < LINES; i++) begin : g_line
      logic             v_q, d_q;
      logic [TAG_W-1:0] t_q;
      logic             sel;
      assign sel = (idx == IDX_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            d_q <= 1'b0;
         end else if (sel) begin
            if (fill_en) begin
               v_q <= 1'b1;
               d_q <= 1'b0;
            end else if (dirty_set) begin
               d_q <= 1'b1;
            end else if (dirty_clr) begin
               d_q <= 1'b0;
            end
         end
      end

      always_ff @(posedge clk) begin
         if (sel && fill_en) t_q <= fill_tag;
      end

      assign valid_vec[i] = v_q;
      assign dirty_vec[i] = d_q;
      assign tag_arr[i]   = t_q;
   end

   assign rd_valid = valid_vec[idx];
   assign rd_dirty = dirty_vec[idx];
   assign rd_tag   = tag_arr[idx];

   // R3: a fill leaves the line valid and clean
   a_r3_fill_valid_clean: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en |=> valid_vec[$past(idx)] && !dirty_vec[$past(idx)]);

   // R9: a flushed line becomes clean and stays valid
   a_r9_clear_keeps_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (dirty_clr && !fill_en) |=> !dirty_vec[$past(idx)] && valid_vec[$past(idx)]);

   // R6: a dirty mark only lands on a valid line
   a_r6_dirty_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (dirty_vec & ~valid_vec) == '0);
endmodule

// File: rtl/wpc_data_store.sv
module wpc_data_store #(
   parameter int LINES  = 16,
   parameter int WORDS  = 4,
   parameter int WORD_W = 32,
   localparam int IDX_W  = $clog2(LINES),
   localparam int OFF_W  = $clog2(WORDS),
   localparam int LINE_W = WORDS * WORD_W
) (
   input  logic              clk,
   input  logic [IDX_W-1:0]  idx,
   input  logic [OFF_W-1:0]  off,
   input  logic              line_we,
   input  logic [LINE_W-1:0] line_wdata,
   input  logic              word_we,
   input  logic [WORD_W-1:0] word_wdata,
   output logic [LINE_W-1:0] rd_line
);
   logic [LINE_W-1:0] mem_q [LINES];

   initial begin
      assert (WORDS >= 2 && (WORDS & (WORDS - 1)) == 0)
         else $error("wpc_data_store: WORDS must be a power of two");
   end

   always_ff @(posedge clk) begin
      if (line_we) begin
         mem_q[idx] <= line_wdata;
      end else if (word_we) begin
         for (int w = 0; w < WORDS; w++) begin
            if (off == OFF_W'(w)) mem_q[idx][w*WORD_W +: WORD_W] <= word_wdata;
         end
      end
   end

   assign rd_line = mem_q[idx];
endmodule

// File: rtl/wpc_ctrl.sv
module wpc_ctrl
   import wpc_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int WORD_W = 32,
   parameter int WORDS  = 4,
   parameter int LINES  = 16,
   localparam int OFF_W   = $clog2(WORDS),
   localparam int IDX_W   = $clog2(LINES),
   localparam int TAG_W   = ADDR_W - OFF_W - IDX_W,
   localparam int MADDR_W = ADDR_W - OFF_W,
   localparam int LINE_W  = WORDS * WORD_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wb_mode,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic               req_write,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [WORD_W-1:0]  req_wdata,
   output logic               rsp_valid,
   output logic [WORD_W-1:0]  rsp_rdata,
   input  logic               flush_req,
   output logic               flush_done,
   output logic               mem_valid,
   input  logic               mem_ack,
   output logic               mem_write,
   output logic [MADDR_W-1:0] mem_addr,
   output logic [WORDS-1:0]   mem_wmask,
   output logic [LINE_W-1:0]  mem_wline,
   output logic [IDX_W-1:0]   arr_idx,
   output logic [OFF_W-1:0]   arr_off,
   input  logic               ln_valid,
   input  logic               ln_dirty,
   input  logic [TAG_W-1:0]   ln_tag,
   input  logic [LINE_W-1:0]  ln_data,
   output logic               fill_en,
   output logic [TAG_W-1:0]   fill_tag,
   output logic               dirty_set,
   output logic               dirty_clr,
   output logic               word_we,
   output logic [WORD_W-1:0]  word_wdata
);
   wpc_state_e        st;
   logic              cur_write;
   logic [ADDR_W-1:0] cur_addr;
   logic [WORD_W-1:0] cur_wdata;
   logic [IDX_W-1:0]  fl_idx;

   logic [OFF_W-1:0] cur_off;
   logic [IDX_W-1:0] cur_idx;
   logic [TAG_W-1:0] cur_tag;
   logic             hit, victim_dirty, fl_step;

   initial begin
      assert (TAG_W >= 1) else $error("wpc_ctrl: address too narrow for tag");
      assert (WORD_W >= 8) else $error("wpc_ctrl: word narrower than a byte");
   end

   assign cur_off = cur_addr[OFF_W-1:0];
   assign cur_idx = cur_addr[OFF_W +: IDX_W];
   assign cur_tag = cur_addr[ADDR_W-1 -: TAG_W];

   assign arr_idx      = (st == ST_FLUSH) ? fl_idx : cur_idx;
   assign arr_off      = cur_off;
   assign hit          = ln_valid && (ln_tag == cur_tag);
   assign victim_dirty = ln_valid && ln_dirty;
   assign fl_step      = !victim_dirty || mem_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         cur_write  <= 1'b0;
         cur_addr   <= '0;
         cur_wdata  <= '0;
         fl_idx     <= '0;
         flush_done <= 1'b0;
      end else begin
         flush_done <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (flush_req) begin
                  st     <= ST_FLUSH;
                  fl_idx <= '0;
               end else if (req_valid) begin
                  st        <= ST_LOOKUP;
                  cur_write <= req_write;
                  cur_addr  <= req_addr;
                  cur_wdata <= req_wdata;
               end
            end
            ST_LOOKUP: begin
               if (cur_write && !wb_mode) st <= ST_WRITE_THRU;
               else if (hit)              st <= ST_IDLE;
               else if (victim_dirty)     st <= ST_WRITEBACK;
               else                       st <= ST_FILL;
            end
            ST_WRITEBACK: if (mem_ack) st <= ST_FILL;
            ST_FILL:      if (mem_ack) st <= ST_LOOKUP;
            ST_WRITE_THRU: if (mem_ack) st <= ST_IDLE;
            ST_FLUSH: begin
               if (fl_step) begin
                  if (fl_idx == IDX_W'(LINES - 1)) begin
                     st         <= ST_IDLE;
                     flush_done <= 1'b1;
                  end else begin
                     fl_idx <= fl_idx + IDX_W'(1);
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (st == ST_IDLE) && !flush_req;
   assign rsp_valid = (st == ST_LOOKUP) && hit && !cur_write;
   assign rsp_rdata = ln_data[cur_off*WORD_W +: WORD_W];

   always_comb begin
      mem_valid = 1'b0;
      mem_write = 1'b1;
      mem_addr  = {ln_tag, arr_idx};
      mem_wmask = '1;
      mem_wline = ln_data;
      case (st)
         ST_WRITEBACK: mem_valid = 1'b1;
         ST_FILL: begin
            mem_valid = 1'b1;
            mem_write = 1'b0;
            mem_addr  = {cur_tag, cur_idx};
         end
         ST_WRITE_THRU: begin
            mem_valid = 1'b1;
            mem_addr  = cur_addr[ADDR_W-1:OFF_W];
            mem_wmask = WORDS'(1) << cur_off;
            mem_wline = {WORDS{cur_wdata}};
         end
         ST_FLUSH: mem_valid = victim_dirty;
         default: ;
      endcase
   end

   assign fill_en    = (st == ST_FILL) && mem_ack;
   assign fill_tag   = cur_tag;
   assign word_we    = (st == ST_LOOKUP) && hit && cur_write;
   assign word_wdata = cur_wdata;
   assign dirty_set  = word_we && wb_mode;
   assign dirty_clr  = (st == ST_FLUSH) && mem_ack;

   // R10: busy right after a request is taken
   a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R11: a pending memory transaction holds still until acknowledged
   a_r11_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ack) |=> mem_valid && $stable(mem_write) && $stable(mem_addr)
                                  && $stable(mem_wmask) && $stable(mem_wline));

   // R9: done is a single-cycle pulse
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      flush_done |=> !flush_done);

   // R2: a hit answer never overlaps memory traffic
   a_r2_hit_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !mem_valid);

   // R8: the write-out of a dirty victim is followed by the line read
   a_r8_fill_follows_evict: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_write && &mem_wmask && mem_ack && !flush_done && !req_ready
       && !dirty_clr) |=> mem_valid && !mem_write);
endmodule

// File: rtl/wpc_cache.sv
module wpc_cache #(
   parameter int ADDR_W = 10,
   parameter int WORD_W = 32,
   parameter int WORDS  = 4,
   parameter int LINES  = 16,
   localparam int OFF_W   = $clog2(WORDS),
   localparam int IDX_W   = $clog2(LINES),
   localparam int TAG_W   = ADDR_W - OFF_W - IDX_W,
   localparam int MADDR_W = ADDR_W - OFF_W,
   localparam int LINE_W  = WORDS * WORD_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wb_mode,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic               req_write,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [WORD_W-1:0]  req_wdata,
   output logic               rsp_valid,
   output logic [WORD_W-1:0]  rsp_rdata,
   input  logic               flush_req,
   output logic               flush_done,
   output logic               mem_valid,
   input  logic               mem_ack,
   output logic               mem_write,
   output logic [MADDR_W-1:0] mem_addr,
   output logic [WORDS-1:0]   mem_wmask,
   output logic [LINE_W-1:0]  mem_wline,
   input  logic [LINE_W-1:0]  mem_rline
);
   logic [IDX_W-1:0]  arr_idx;
   logic [OFF_W-1:0]  arr_off;
   logic              ln_valid, ln_dirty;
   logic [TAG_W-1:0]  ln_tag, fill_tag;
   logic [LINE_W-1:0] ln_data;
   logic              fill_en, dirty_set, dirty_clr, word_we;
   logic [WORD_W-1:0] word_wdata;
   logic [LINES-1:0]  valid_vec, dirty_vec;

   wpc_ctrl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .WORDS(WORDS), .LINES(LINES)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wb_mode(wb_mode),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .flush_req(flush_req), .flush_done(flush_done),
      .mem_valid(mem_valid), .mem_ack(mem_ack), .mem_write(mem_write),
      .mem_addr(mem_addr), .mem_wmask(mem_wmask), .mem_wline(mem_wline),
      .arr_idx(arr_idx), .arr_off(arr_off),
      .ln_valid(ln_valid), .ln_dirty(ln_dirty), .ln_tag(ln_tag), .ln_data(ln_data),
      .fill_en(fill_en), .fill_tag(fill_tag), .dirty_set(dirty_set),
      .dirty_clr(dirty_clr), .word_we(word_we), .word_wdata(word_wdata)
   );

   wpc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
      .clk(clk), .rst_n(rst_n), .idx(arr_idx),
      .fill_en(fill_en), .fill_tag(fill_tag),
      .dirty_set(dirty_set), .dirty_clr(dirty_clr),
      .rd_valid(ln_valid), .rd_dirty(ln_dirty), .rd_tag(ln_tag),
      .valid_vec(valid_vec), .dirty_vec(dirty_vec)
   );

   wpc_data_store #(.LINES(LINES), .WORDS(WORDS), .WORD_W(WORD_W)) u_data (
      .clk(clk), .idx(arr_idx), .off(arr_off),
      .line_we(fill_en), .line_wdata(mem_rline),
      .word_we(word_we), .word_wdata(word_wdata),
      .rd_line(ln_data)
   );

   // R4: write-through operation never leaves a dirty line
   a_r4_wt_never_dirty: assert property (@(posedge clk) disable iff (!rst_n)
      !wb_mode |-> (dirty_vec == '0));

   // R9: at the end of a flush no line is dirty
   a_r9_flush_leaves_clean: assert property (@(posedge clk) disable iff (!rst_n)
      flush_done |-> (dirty_vec == '0));

   // R5: a write-through miss adds no valid line
   a_r5_no_allocate: assert property (@(posedge clk) disable iff (!rst_n)
      (!wb_mode && mem_valid && mem_write) |=> $stable(valid_vec));
endmodule

// File: tb/tb_wpc_cache.sv
module tb_wpc_cache;
   localparam int AW = 10, WW = 32, NW = 4, NL = 16;
   localparam int LW = NW * WW, MAW = AW - 2;

   logic clk = 1'b0, rst_n = 1'b0, wb_mode = 1'b1;
   logic req_valid = 1'b0, req_write = 1'b0, flush_req = 1'b0, mem_ack = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [WW-1:0] req_wdata = '0, rsp_rdata;
   logic req_ready, rsp_valid, flush_done, mem_valid, mem_write;
   logic [MAW-1:0] mem_addr;
   logic [NW-1:0] mem_wmask;
   logic [LW-1:0] mem_wline, mem_rline = '0;

   wpc_cache #(.ADDR_W(AW), .WORD_W(WW), .WORDS(NW), .LINES(NL)) dut (
      .clk(clk), .rst_n(rst_n), .wb_mode(wb_mode),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .flush_req(flush_req), .flush_done(flush_done),
      .mem_valid(mem_valid), .mem_ack(mem_ack), .mem_write(mem_write),
      .mem_addr(mem_addr), .mem_wmask(mem_wmask), .mem_wline(mem_wline),
      .mem_rline(mem_rline)
   );

   always #2 clk = ~clk;

   int n_checks = 0, n_fail = 0, cyc = 0;
   logic [WW-1:0] bmem [1024];
   logic [WW-1:0] gold [1024];
   bit            log_w [64];
   logic [MAW-1:0] log_a [64];
   logic [NW-1:0] log_m [64];
   int log_n = 0, wait_cnt = 0;
   bit busy = 0, cap_w = 0;
   logic [MAW-1:0] cap_a = '0;

   function automatic logic [WW-1:0] init_word(input int a);
      return WW'(a) * 32'h9E37_79B1 ^ 32'h0000_5A5A;
   endfunction

   task automatic check(input bit ok, input string rq, input logic [63:0] act,
                        input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   // backing memory with random acknowledge delay
   always @(negedge clk) begin
      if (!rst_n) begin
         mem_ack = 0; wait_cnt = 0; busy = 0; log_n = 0;
         for (int a = 0; a < 1024; a++) bmem[a] = init_word(a);
      end else if (mem_ack) begin
         mem_ack = 0; busy = 0; wait_cnt = $urandom % 4;
      end else if (mem_valid) begin
         if (!busy) begin busy = 1; cap_a = mem_addr; cap_w = mem_write; end
         if (wait_cnt == 0) begin
            check(mem_addr == cap_a && mem_write == cap_w, "R11 hold",
                  {mem_write, mem_addr}, {cap_w, cap_a});
            for (int w = 0; w < NW; w++) begin
               if (mem_write) begin
                  if (mem_wmask[w]) bmem[{mem_addr, 2'(w)}] = mem_wline[w*WW +: WW];
               end else begin
                  mem_rline[w*WW +: WW] = bmem[{mem_addr, 2'(w)}];
               end
            end
            log_w[log_n & 63] = mem_write;
            log_a[log_n & 63] = mem_addr;
            log_m[log_n & 63] = mem_wmask;
            log_n++;
            mem_ack = 1;
         end else begin
            wait_cnt--;
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog all-reqs actual=%0d expected<150000", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   task automatic do_reset(input bit mode);
      @(negedge clk);
      rst_n = 0; wb_mode = mode; req_valid = 0; flush_req = 0;
      for (int a = 0; a < 1024; a++) gold[a] = init_word(a);
      repeat (3) @(negedge clk);
      rst_n = 1;
   endtask

   task automatic do_req(input bit wr, input logic [AW-1:0] a, input logic [WW-1:0] d,
                         output logic [WW-1:0] q, output int lat);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
      @(posedge clk);
      @(negedge clk);
      req_valid = 0;
      check(req_ready == 0, "R10 busy", req_ready, 0);
      lat = 1;
      q = '0;
      if (!wr) begin
         while (!rsp_valid) begin @(negedge clk); lat++; end
         q = rsp_rdata;
      end else begin
         while (!req_ready) begin @(negedge clk); lat++; end
         gold[a] = d;
      end
   endtask

   task automatic rd(input logic [AW-1:0] a, input string rq, output int lat);
      logic [WW-1:0] q;
      do_req(0, a, '0, q, lat);
      check(q == gold[a], rq, q, gold[a]);
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [WW-1:0] d);
      logic [WW-1:0] q;
      int lat;
      do_req(1, a, d, q, lat);
   endtask

   task automatic do_flush();
      @(negedge clk);
      flush_req = 1;
      #1 check(req_ready == 0, "R10 flush blocks", req_ready, 0);
      @(negedge clk);
      while (!flush_done) @(negedge clk);
      flush_req = 0;
      @(negedge clk);
      check(flush_done == 0, "R9 pulse width", flush_done, 0);
   endtask

   task automatic random_ops(input int n);
      logic [WW-1:0] q;
      int lat;
      for (int k = 0; k < n; k++) begin
         logic [AW-1:0] a;
         a = AW'((($urandom % 4) << 6) | (($urandom % 4) << 2) | ($urandom % 4));
         if ($urandom % 2) begin
            do_req(1, a, $urandom, q, lat);
         end else begin
            do_req(0, a, '0, q, lat);
            check(q == gold[a], "R3 random read", q, gold[a]);
         end
      end
   endtask

   localparam logic [AW-1:0] A = 10'h010, B = 10'h050, C = 10'h014, D = 10'h018;

   initial begin
      int lat, n0, bad;
      void'($urandom(32'd2024));

      // write-back mode, directed
      do_reset(1);
      @(negedge clk);
      check(req_ready == 1, "R1 ready", req_ready, 1);
      check(mem_valid == 0, "R1 mem idle", mem_valid, 0);
      check(flush_done == 0, "R1 done low", flush_done, 0);
      rd(A, "R3 miss data", lat);
      check(log_n == 1 && log_w[0] == 0, "R1 first read fills", log_n, 1);
      check(log_a[0] == 8'h04, "R12 fill line address", log_a[0], 8'h04);
      rd(A, "R2 hit data", lat);
      check(lat == 1, "R2 hit latency", lat, 1);
      check(log_n == 1, "R2 no mem on hit", log_n, 1);
      wr(A + 1, 32'hCAFE_0001);
      check(log_n == 1, "R6 write hit no mem", log_n, 1);
      rd(A + 1, "R6 reads new word", lat);
      check(lat == 1, "R6 hit latency", lat, 1);
      wr(B, 32'hBEEF_0002);
      check(log_n == 3, "R8 two transactions", log_n, 3);
      check(log_w[1] == 1 && log_a[1] == 8'h04 && log_m[1] == 4'hF, "R8 evict first",
            {log_w[1], log_a[1], log_m[1]}, {1'b1, 8'h04, 4'hF});
      check(log_w[2] == 0 && log_a[2] == 8'h14, "R8 then fill",
            {log_w[2], log_a[2]}, {1'b0, 8'h14});
      check(bmem[A + 1] == 32'hCAFE_0001, "R8 old line written", bmem[A + 1], 32'hCAFE_0001);
      rd(B, "R7 merged word", lat);
      check(lat == 1 && log_n == 3, "R7 allocated line hits", log_n, 3);
      wr(C, 32'h1234_5678);
      check(log_n == 4 && log_w[3] == 0 && log_a[3] == 8'h05, "R7 clean victim one read",
            {log_n[7:0], log_w[3], log_a[3]}, {8'd4, 1'b0, 8'h05});
      do_flush();
      check(log_n == 6, "R9 writes per dirty line", log_n, 6);
      check(log_a[4] == 8'h14 && log_a[5] == 8'h05 && log_w[4] && log_w[5]
            && log_m[4] == 4'hF && log_m[5] == 4'hF, "R9 index order",
            {log_a[4], log_a[5]}, {8'h14, 8'h05});
      check(bmem[B] == 32'hBEEF_0002 && bmem[C] == 32'h1234_5678, "R9 data out",
            bmem[B], 32'hBEEF_0002);
      rd(B, "R9 line kept", lat);
      check(lat == 1 && log_n == 6, "R9 still valid", log_n, 6);
      do_flush();
      check(log_n == 6, "R9 clean after flush", log_n, 6);

      // write-back mode, random
      random_ops(400);
      do_flush();
      bad = 0;
      for (int a = 0; a < 1024; a++) if (bmem[a] != gold[a]) bad++;
      check(bad == 0, "R9 memory matches after flush", bad, 0);

      // write-through mode, directed
      do_reset(0);
      @(negedge clk);
      check(req_ready == 1 && mem_valid == 0, "R1 ready after reset", req_ready, 1);
      rd(A, "R3 miss data wt", lat);
      n0 = log_n;
      wr(A + 2, 32'h0F0F_2222);
      check(log_n == n0 + 1 && log_w[n0 & 63] && log_a[n0 & 63] == 8'h04
            && log_m[n0 & 63] == 4'b0100, "R4 single word write",
            {log_a[n0 & 63], log_m[n0 & 63]}, {8'h04, 4'b0100});
      check(bmem[A + 2] == 32'h0F0F_2222, "R4 memory updated", bmem[A + 2], 32'h0F0F_2222);
      rd(A + 2, "R4 cache updated", lat);
      check(lat == 1, "R4 hit after write", lat, 1);
      n0 = log_n;
      wr(D, 32'h5555_AAAA);
      check(log_n == n0 + 1 && log_a[n0 & 63] == 8'h06 && log_m[n0 & 63] == 4'b0001,
            "R5 miss write to memory", {log_a[n0 & 63], log_m[n0 & 63]}, {8'h06, 4'b0001});
      n0 = log_n;
      rd(D, "R5 data from memory", lat);
      check(log_n == n0 + 1 && log_w[n0 & 63] == 0 && log_a[n0 & 63] == 8'h06,
            "R5 no allocation", log_n, n0 + 1);

      // write-through mode, random
      random_ops(300);
      bad = 0;
      for (int a = 0; a < 1024; a++) if (bmem[a] != gold[a]) bad++;
      check(bad == 0, "R4 memory always current", bad, 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule